// File: doc/BRIEF.md
# Two-Sided Parallel Port Register File

This block is the processor-facing register file of an 8-bit parallel port adapter with two identical sides, A and B. Each side holds a direction register (one bit per pin, 1 = drive), an output register and a control register. The processor sees only two locations per side. The direction register and the output register share one location, and bit 2 of that side's control register selects which of the two that location reaches.

The control register keeps six writable configuration bits. It also holds two event flags in its top bits, and the processor can only read those flags. Edge detection on the side's handshake lines is done elsewhere. That logic sets the flags through one-cycle pulses and reads the configuration bits back from this block. A processor read of the output location clears both flags of that side. The block combines the flags with their enable bits to form one interrupt request per side.

The block is clocked. An access takes effect in a cycle where the bus enable is high and the three select inputs match. Read data is combinational during the access cycle. Writes and flag clears land on the next rising edge.

Top module: `pio_regfile`

## Requirements
- R1: An active-low reset clears the direction, output, configuration and flag state of both sides to zero. All pins are then inputs with output value 0, both interrupt requests are low, and all four locations read 0x00.
- R2: An access takes place only when bus_en=1, sel_p0=1, sel_p1=1 and sel_n=0. Any other combination writes nothing, clears no flag and returns rdata=0.
- R3: reg_addr selects the location. 0 is the A data location, 1 is A control, 2 is the B data location and 3 is B control.
- R4: While control bit 2 of a side is 0, the data location reads and writes that side's direction register, and port*_oe equals the direction register.
- R5: While control bit 2 is 1, a write to the data location loads the output register, which drives port*_out. The direction register is left unchanged.
- R6: While control bit 2 is 1, a read of the data location returns the pin input for every bit whose direction bit is 0, and the output register for every bit whose direction bit is 1.
- R7: A control write stores write-data bits 5..0. Bits 7..6 of the write data are ignored. A control read returns {flag7, flag6, config[5:0]}.
- R8: A pulse on port*_evt[1] sets control bit 7, and a pulse on port*_evt[0] sets control bit 6.
- R9: Both flags of a side are cleared only by a read of that side's data location while control bit 2 is 1. Control reads, direction reads and control writes leave the flags set.
- R10: If a set pulse arrives in the same cycle as a clearing read, the pulsed flag is set after that edge.
- R11: port*_irq = (bit7 AND config bit 0) OR (bit6 AND config bit 3 AND NOT config bit 5).
- R12: port*_cfg always shows config bits 5..0 of that side.
- R13: An access to one side never changes the other side's state or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_p0 | input | 1 | Select, active high |
| sel_p1 | input | 1 | Select, active high |
| sel_n | input | 1 | Select, active low |
| reg_addr | input | 2 | Location select |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_en | input | 1 | Access strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| porta_in | input | 8 | Side A pin levels |
| porta_out | output | 8 | Side A output register |
| porta_oe | output | 8 | Side A drive enables |
| porta_evt | input | 2 | Side A flag-set pulses ([1] to bit 7, [0] to bit 6) |
| porta_cfg | output | 6 | Side A configuration bits |
| porta_irq | output | 1 | Side A interrupt request |
| portb_in | input | 8 | Side B pin levels |
| portb_out | output | 8 | Side B output register |
| portb_oe | output | 8 | Side B drive enables |
| portb_evt | input | 2 | Side B flag-set pulses |
| portb_cfg | output | 6 | Side B configuration bits |
| portb_irq | output | 1 | Side B interrupt request |

## Verification
Each side is swept through sixteen direction patterns. Every pattern pairs an unrelated output value with four pin patterns, so any bit taken from the wrong source (pin or output register) shows up in the read-back value. All eight select combinations are tried with the strobe both high and low, and only one combination may reach the register. The interrupt output is checked against all 64 configuration values for each non-empty flag set, which separates the two enable terms and the bit-5 override. Separate flag sequences show that reads which should not clear the flags leave them set, and that a set pulse arriving together with a clearing read keeps its flag.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int SIDES  = 2;
  localparam int LOCS   = 2 * SIDES;
  localparam int ADDR_W = $clog2(LOCS);
  localparam int CFG_W  = 6;
  localparam int CTL_W  = 8;
  localparam int SEL_OR = 2;

  function automatic logic chip_hit(input logic p0, input logic p1, input logic n);
    return p0 & p1 & ~n;
  endfunction

  function automatic logic irq_of(input logic [1:0] fl, input logic [CFG_W-1:0] cfg);
    return (fl[1] & cfg[0]) | (fl[0] & cfg[3] & ~cfg[5]);
  endfunction
endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
(
  input  logic              sel_p0,
  input  logic              sel_p1,
  input  logic              sel_n,
  input  logic              bus_en,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic              acc_sel,
  output logic [LOCS-1:0]   wr_stb,
  output logic [LOCS-1:0]   rd_stb
);
  assign acc_sel = bus_en & chip_hit(sel_p0, sel_p1, sel_n);

  for (genvar l = 0; l < LOCS; l++) begin : g_loc
    logic hit;
    assign hit       = acc_sel && (reg_addr == ADDR_W'(l));
    assign wr_stb[l] = hit & ~rd_nwr;
    assign rd_stb[l] = hit & rd_nwr;
  end
endmodule

// File: rtl/pio_side.sv
module pio_side
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dat,
  input  logic             wr_ctl,
  input  logic             rd_dat,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_in,
  input  logic [1:0]       evt,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     dir_q,
  output logic [CFG_W-1:0] cfg_q,
  output logic [1:0]       flags_q,
  output logic [W-1:0]     dat_rd,
  output logic [CTL_W-1:0] ctl_rd,
  output logic             irq,
  output logic             clr_ev
);
  function automatic logic [W-1:0] merge(input logic [W-1:0] pin, input logic [W-1:0] ov,
                                         input logic [W-1:0] dir);
    return (pin & ~dir) | (ov & dir);
  endfunction

  logic to_or;
  assign to_or  = cfg_q[SEL_OR];
  assign clr_ev = rd_dat & to_or;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      cfg_q   <= '0;
      flags_q <= '0;
    end else begin
      if (wr_dat && !to_or) dir_q <= wdata;
      if (wr_dat && to_or)  out_q <= wdata;
      if (wr_ctl)           cfg_q <= wdata[CFG_W-1:0];
      flags_q <= (flags_q & ~{2{clr_ev}}) | evt;
    end
  end

  assign dat_rd = to_or ? merge(pin_in, out_q, dir_q) : dir_q;
  assign ctl_rd = {flags_q, cfg_q};
  assign irq    = irq_of(flags_q, cfg_q);
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_p0,
  input  logic              sel_p1,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              rd_nwr,
  input  logic              bus_en,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      porta_in,
  output logic [W-1:0]      porta_out,
  output logic [W-1:0]      porta_oe,
  input  logic [1:0]        porta_evt,
  output logic [CFG_W-1:0]  porta_cfg,
  output logic              porta_irq,
  input  logic [W-1:0]      portb_in,
  output logic [W-1:0]      portb_out,
  output logic [W-1:0]      portb_oe,
  input  logic [1:0]        portb_evt,
  output logic [CFG_W-1:0]  portb_cfg,
  output logic              portb_irq
);
  logic            acc_sel;
  logic [LOCS-1:0] wr_stb, rd_stb;

  pio_bus_decode u_dec (
    .sel_p0(sel_p0), .sel_p1(sel_p1), .sel_n(sel_n), .bus_en(bus_en),
    .rd_nwr(rd_nwr), .reg_addr(reg_addr), .acc_sel(acc_sel),
    .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  logic [W-1:0]     pin_s  [SIDES];
  logic [1:0]       evt_s  [SIDES];
  logic [W-1:0]     out_s  [SIDES];
  logic [W-1:0]     dir_s  [SIDES];
  logic [CFG_W-1:0] cfg_s  [SIDES];
  logic [1:0]       flg_s  [SIDES];
  logic [W-1:0]     drd_s  [SIDES];
  logic [CTL_W-1:0] crd_s  [SIDES];
  logic             irq_s  [SIDES];
  logic             clr_s  [SIDES];

  assign pin_s[0] = porta_in;
  assign pin_s[1] = portb_in;
  assign evt_s[0] = porta_evt;
  assign evt_s[1] = portb_evt;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    pio_side #(.W(W)) u_side (
      .clk(clk), .rst_n(rst_n),
      .wr_dat(wr_stb[2*g]), .wr_ctl(wr_stb[2*g+1]), .rd_dat(rd_stb[2*g]),
      .wdata(wdata), .pin_in(pin_s[g]), .evt(evt_s[g]),
      .out_q(out_s[g]), .dir_q(dir_s[g]), .cfg_q(cfg_s[g]), .flags_q(flg_s[g]),
      .dat_rd(drd_s[g]), .ctl_rd(crd_s[g]), .irq(irq_s[g]), .clr_ev(clr_s[g])
    );
  end

  // Named internal events for the checker
  logic [1:0] a_flags, b_flags;
  logic       a_clr, b_clr;
  assign a_flags = flg_s[0];
  assign b_flags = flg_s[1];
  assign a_clr   = clr_s[0];
  assign b_clr   = clr_s[1];

  assign porta_out = out_s[0];
  assign porta_oe  = dir_s[0];
  assign porta_cfg = cfg_s[0];
  assign porta_irq = irq_s[0];
  assign portb_out = out_s[1];
  assign portb_oe  = dir_s[1];
  assign portb_cfg = cfg_s[1];
  assign portb_irq = irq_s[1];

  always_comb begin
    rdata = '0;
    if (|rd_stb) begin
      if (reg_addr[0]) rdata = W'(crd_s[reg_addr[1]]);
      else             rdata = drd_s[reg_addr[1]];
    end
  end
endmodule

// File: rtl/pio_regfile_chk.sv
module pio_regfile_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_sel,
  input logic [W-1:0] porta_out,
  input logic [W-1:0] porta_oe,
  input logic [W-1:0] portb_out,
  input logic [W-1:0] portb_oe,
  input logic         porta_irq,
  input logic         portb_irq,
  input logic [1:0]   porta_evt,
  input logic [1:0]   portb_evt,
  input logic [1:0]   a_flags,
  input logic [1:0]   b_flags,
  input logic         a_clr,
  input logic         b_clr
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (porta_oe == '0 && portb_oe == '0 && porta_out == '0 &&
                portb_out == '0 && !porta_irq && !portb_irq));

  assert_unselected_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_sel |=> ($stable(porta_out) && $stable(porta_oe) &&
                  $stable(portb_out) && $stable(portb_oe)));

  assert_flag7_needs_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !porta_evt[1] |=> !$rose(a_flags[1]));

  assert_flag6_needs_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !portb_evt[0] |=> !$rose(b_flags[0]));

  assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_clr && porta_evt == 2'b00) |=> (a_flags == 2'b00));

  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_clr && b_flags[1]) |=> b_flags[1]);

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_clr && porta_evt[1]) |=> a_flags[1]);

  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (a_flags == 2'b00) |-> !porta_irq);
endmodule

bind pio_regfile pio_regfile_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel),
  .porta_out(porta_out), .porta_oe(porta_oe),
  .portb_out(portb_out), .portb_oe(portb_oe),
  .porta_irq(porta_irq), .portb_irq(portb_irq),
  .porta_evt(porta_evt), .portb_evt(portb_evt),
  .a_flags(a_flags), .b_flags(b_flags), .a_clr(a_clr), .b_clr(b_clr)
);

// File: tb/tb_pio_regfile.sv
module tb_pio_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       sel_p0 = 0, sel_p1 = 0, sel_n = 1;
  logic [1:0] reg_addr = 0;
  logic       rd_nwr = 1, bus_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] porta_in = 0, porta_out, porta_oe;
  logic [7:0] portb_in = 0, portb_out, portb_oe;
  logic [1:0] porta_evt = 0, portb_evt = 0;
  logic [5:0] porta_cfg, portb_cfg;
  logic       porta_irq, portb_irq;

  int vectors = 0, misses = 0;
  logic [7:0] m_dir [2];
  logic [7:0] m_or  [2];

  always #4 clk = ~clk;

  pio_regfile dut (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  // Bus cycle with explicit select combination {p0,p1,n}
  task automatic bus(input logic rw, input logic [2:0] cs, input logic e, input logic [1:0] a,
                     input logic [7:0] d, input logic [7:0] exp, input logic chk_rd,
                     input string req);
    @(negedge clk);
    {sel_p0, sel_p1, sel_n} = cs;
    bus_en = e; rd_nwr = rw; reg_addr = a; wdata = d;
    #1;
    if (chk_rd) chk(rdata, exp, req);
    @(posedge clk); #1;
    bus_en = 0; rd_nwr = 1; {sel_p0, sel_p1, sel_n} = 3'b001;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus(1'b0, 3'b110, 1'b1, a, d, 8'h00, 1'b0, "");
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    bus(1'b1, 3'b110, 1'b1, a, 8'h00, exp, 1'b1, req);
  endtask

  task automatic pulse(input int s, input logic [1:0] fl);
    @(negedge clk);
    if (s == 0) porta_evt = fl; else portb_evt = fl;
    @(posedge clk); #1;
    porta_evt = 0; portb_evt = 0;
  endtask

  function automatic logic [7:0] oe_of(input int s);
    return (s == 0) ? porta_oe : portb_oe;
  endfunction
  function automatic logic [7:0] out_of(input int s);
    return (s == 0) ? porta_out : portb_out;
  endfunction
  function automatic logic irq_model(input logic [1:0] fl, input logic [5:0] c);
    logic e7, e6;
    e7 = c[0] ? fl[1] : 1'b0;
    e6 = (c[5] == 1'b0 && c[3] == 1'b1) ? fl[0] : 1'b0;
    return e7 | e6;
  endfunction

  initial begin
    #(8 * 100000);
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    m_dir[0] = 0; m_dir[1] = 0; m_or[0] = 0; m_or[1] = 0;
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(porta_oe, 8'h00, "R1 oe A"); chk(portb_oe, 8'h00, "R1 oe B");
    chk(8'(porta_irq), 0, "R1 irq A"); chk(8'(portb_irq), 0, "R1 irq B");
    rst_n = 1;
    for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R1 R3 reset read");

    // Direction / output / merge sweep, both sides (R3 R4 R5 R6 R13)
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] dv, ov, pv;
        logic [1:0] base;
        base = 2'(2 * s);
        dv = 8'(k * 17) ^ 8'h5A;
        ov = ~dv ^ 8'(k << 2);
        wr(base + 1, 8'h00);
        wr(base, dv); m_dir[s] = dv;
        rd(base, dv, "R4 direction readback");
        chk(oe_of(s), dv, "R4 oe");
        chk(oe_of(1 - s), m_dir[1 - s], "R13 other side oe");
        wr(base + 1, 8'h04);
        wr(base, ov); m_or[s] = ov;
        @(negedge clk);
        chk(out_of(s), ov, "R5 out");
        chk(oe_of(s), dv, "R5 direction kept");
        chk(out_of(1 - s), m_or[1 - s], "R13 other side out");
        for (int p = 0; p < 4; p++) begin
          pv = 8'(p * 8'h5B) ^ 8'(k);
          if (s == 0) porta_in = pv; else portb_in = pv;
          rd(base, (pv & ~dv) | (ov & dv), "R6 merged read");
        end
      end
      wr(2'(2 * s + 1), 8'h00);
    end

    // Select sweep (R2)
    for (int c = 0; c < 8; c++) begin
      for (int e = 0; e < 2; e++) begin
        logic hit;
        hit = (c == 3'b110) && (e == 1);
        wr(2'd1, 8'h00);
        bus(1'b0, 3'(c), 1'(e), 2'd1, 8'h3F, 8'h00, 1'b0, "");
        bus(1'b1, 3'(c), 1'(e), 2'd1, 8'h00, hit ? 8'h3F : 8'h00, 1'b1, "R2 select read");
        rd(2'd1, hit ? 8'h3F : 8'h00, "R2 select write");
      end
    end

    // Control write masking (R7)
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h3F, "R7 high bits ignored");
    wr(2'd1, 8'h00);

    // Flags set / non-clearing reads / clearing read (R8 R9)
    pulse(0, 2'b10);
    rd(2'd1, 8'h80, "R8 bit7 set");
    pulse(0, 2'b01);
    rd(2'd1, 8'hC0, "R8 bit6 set, R9 ctl read keeps");
    rd(2'd0, m_dir[0], "R9 direction read");
    rd(2'd1, 8'hC0, "R9 direction read keeps");
    wr(2'd1, 8'h04);
    rd(2'd1, 8'hC4, "R9 R7 ctl write keeps flags");
    rd(2'd3, 8'h00, "R13 B flags untouched");
    rd(2'd0, (porta_in & ~m_dir[0]) | (m_or[0] & m_dir[0]), "R9 clearing read");
    rd(2'd1, 8'h04, "R9 cleared");

    // Set pulse together with clearing read (R10)
    @(negedge clk);
    {sel_p0, sel_p1, sel_n} = 3'b110; bus_en = 1; rd_nwr = 1; reg_addr = 2'd0;
    porta_evt = 2'b10;
    @(posedge clk); #1;
    bus_en = 0; porta_evt = 0; {sel_p0, sel_p1, sel_n} = 3'b001;
    rd(2'd1, 8'h84, "R10 set wins");

    // Interrupt and configuration sweep (R11 R12)
    for (int s = 0; s < 2; s++) begin
      for (int f = 1; f < 4; f++) begin
        wr(2'(2 * s + 1), 8'h04);
        rd(2'(2 * s), (s == 0) ? ((porta_in & ~m_dir[0]) | (m_or[0] & m_dir[0]))
                               : ((portb_in & ~m_dir[1]) | (m_or[1] & m_dir[1])), "R9 clear");
        pulse(s, 2'(f));
        for (int c = 0; c < 64; c++) begin
          wr(2'(2 * s + 1), 8'(c));
          @(negedge clk);
          chk(8'((s == 0) ? porta_irq : portb_irq), 8'(irq_model(2'(f), 6'(c))), "R11 irq");
          chk(8'((s == 0) ? porta_cfg : portb_cfg), 8'(c), "R12 cfg");
        end
      end
    end

    // Reset again from a busy state (R1)
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R1 re-reset read");
    @(negedge clk);
    chk(porta_out, 8'h00, "R1 out A"); chk(portb_out, 8'h00, "R1 out B");
    chk(8'(porta_irq), 0, "R1 irq A");
    summary();
  end
endmodule